// File: doc/BRIEF.md
# Long Instruction Assembler

This block watches a stream of 32-bit instruction slot words and picks out the pieces of instructions that are wider than one slot. A wide instruction opens with a header word that states how many slots it spans. Each later piece carries its own position tag. Ordinary single-slot words, including words that hold two 16-bit instructions, may fall between the pieces. Those ordinary words leave on a separate pass-through port one cycle after they arrive. They are never altered and never held back.

The pieces are matched by their position tags, so they may arrive in any order. When every position that the header asked for has arrived, the block presents one wide word. That word holds the header payload first, then the continuation payloads in ascending position order. It is held with a valid/ready handshake until a consumer takes it. The same gathering serves true wide instructions and prefix or parallel-issue groupings. Malformed sequences raise a one-cycle error pulse and discard the partial work.

Top module: `long_insn_gather`

## Requirements
- R1: During and right after reset, thruValid, longValid and errFlag are low and inReady is high.
- R2: An accepted word whose bits [31:27] are not all ones appears unchanged on thruWord, with thruValid high, in the cycle after it is accepted. Such a word is never stalled.
- R3: A word with bits [31:27] = 11111 and bits [26:25] = 00 is a header. Its length is in bits [24:22] and its 22-bit payload in bits [21:0]. Any other word with bits [31:27] = 11111 is a continuation, with its position in bits [26:24] and its 24-bit payload in bits [23:0]. Neither kind is ever forwarded on the pass-through port.
- R4: Once continuations for every position 2..len have been accepted after a header, in any order, longValid rises in the next cycle. At that point longLen equals len and longData[165:144] holds the header payload. The payload of position p sits at longData[191-24p -: 24], and the slices for positions above len are zero.
- R5: Ordinary words that fall between the pieces of an open wide instruction are forwarded and leave the assembly undisturbed.
- R6: A header whose length is 0 or 1 gives errFlag high for one cycle and opens nothing.
- R7: A continuation that arrives with no open header gives errFlag high for one cycle and produces no output.
- R8: A continuation whose position exceeds the open header's length gives an error pulse and discards the partial instruction.
- R9: A continuation that repeats a position already received gives an error pulse and discards the partial instruction.
- R10: A header that arrives while an assembly is incomplete gives an error pulse and starts a fresh assembly from the new header.
- R11: While longValid is high and longReady is low, longData and longLen hold steady and header or continuation words see inReady low. Ordinary words are still accepted.
- R12: A header or continuation word is accepted in the same cycle in which the held output is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Slot word present |
| inWord | input | 32 | Slot word |
| inReady | output | 1 | Slot word can be accepted this cycle |
| thruValid | output | 1 | Forwarded ordinary word valid |
| thruWord | output | 32 | Forwarded ordinary word |
| longValid | output | 1 | Assembled wide instruction valid |
| longReady | input | 1 | Consumer takes the wide instruction |
| longData | output | 166 | Assembled payloads, header first |
| longLen | output | 3 | Slot count of the assembled instruction |
| errFlag | output | 1 | One-cycle pulse for a malformed sequence |

## Verification
Two functions can meet in one cycle: the consumer taking a held wide instruction, and a new header or continuation arriving at the input. The bench first holds longReady low while a header waits at the input. There it checks that inReady stays low and that the held data does not change, and that an ordinary word still gets through. It then raises longReady in the same cycle as a new header. That header must be accepted at once, longValid must drop in the next cycle, and the following continuation must complete a new instruction carrying the new payloads.

// File: rtl/lig_pkg.sv
package lig_pkg;
  localparam int WORD_W    = 32;
  localparam int TAG_W     = 5;
  localparam int HDR_PAY_W = 22;
  localparam int PART_PAY_W = 24;
  localparam int LEN_W     = 3;
  localparam int MAX_SLOTS = 7;
  localparam int NUM_PARTS = MAX_SLOTS - 1;
  localparam int OUT_W     = HDR_PAY_W + NUM_PARTS * PART_PAY_W;
  localparam logic [TAG_W-1:0] LONG_TAG = '1;

  typedef struct packed {
    logic passThru;
    logic startHdr;
    logic storePart;
    logic finish;
    logic flagErr;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] partIdx;
  } ctrlStrobeT;
endpackage

// File: rtl/lig_ctrl.sv
module lig_ctrl
  import lig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic              longValid,
  input  logic              longReady,
  output logic              inReady,
  output ctrlStrobeT        st
);
  logic                 openQ, openD;
  logic [LEN_W-1:0]     lenQ, lenD;
  logic [NUM_PARTS-1:0] seenQ, seenD, seenNew;
  logic                 isLong, isHdr, take;
  logic [LEN_W-1:0]     hdrLen, pos, posIdx;

  always_comb begin
    isLong  = inWord[WORD_W-1 -: TAG_W] == LONG_TAG;
    isHdr   = isLong && (inWord[26:25] == 2'b00);
    hdrLen  = inWord[24:22];
    pos     = inWord[26:24];
    posIdx  = pos - 3'd2;
    seenNew = seenQ | (NUM_PARTS'(1) << posIdx);
    inReady = !(isLong && longValid && !longReady);
    take    = inValid && inReady;

    st         = '0;
    st.len     = isHdr ? hdrLen : lenQ;
    st.partIdx = posIdx;
    openD      = openQ;
    lenD       = lenQ;
    seenD      = seenQ;

    if (take) begin
      if (!isLong) begin
        st.passThru = 1'b1;
      end else if (isHdr) begin
        st.flagErr = openQ || (hdrLen < 3'd2);
        if (hdrLen >= 3'd2) begin
          st.startHdr = 1'b1;
          openD       = 1'b1;
          lenD        = hdrLen;
          seenD       = '0;
        end else begin
          openD = 1'b0;
        end
      end else if (!openQ) begin
        st.flagErr = 1'b1;
      end else if ((pos > lenQ) || seenQ[posIdx]) begin
        st.flagErr = 1'b1;
        openD      = 1'b0;
      end else begin
        st.storePart = 1'b1;
        seenD        = seenNew;
        if ($countones(seenNew) == int'(lenQ) - 1) begin
          st.finish = 1'b1;
          openD     = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openQ <= 1'b0;
      lenQ  <= '0;
      seenQ <= '0;
    end else begin
      openQ <= openD;
      lenQ  <= lenD;
      seenQ <= seenD;
    end
  end
endmodule

// File: rtl/lig_datapath.sv
module lig_datapath
  import lig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  ctrlStrobeT        st,
  input  logic              longReady,
  output logic              thruValid,
  output logic [WORD_W-1:0] thruWord,
  output logic              longValid,
  output logic [OUT_W-1:0]  longData,
  output logic [LEN_W-1:0]  longLen,
  output logic              errFlag
);
  logic [HDR_PAY_W-1:0]  hdrQ;
  logic [PART_PAY_W-1:0] partQ [NUM_PARTS];
  logic [OUT_W-1:0]      assembled;

  assign assembled[OUT_W-1 -: HDR_PAY_W] = hdrQ;

  for (genvar i = 0; i < NUM_PARTS; i++) begin : gSlot
    localparam int TOP = OUT_W - HDR_PAY_W - 1 - i * PART_PAY_W;
    logic hit;
    assign hit = st.storePart && (st.partIdx == LEN_W'(i));
    assign assembled[TOP -: PART_PAY_W] = hit ? inWord[PART_PAY_W-1:0] : partQ[i];

    always_ff @(posedge clk) begin
      if (!rstN || st.startHdr) partQ[i] <= '0;
      else if (hit)             partQ[i] <= inWord[PART_PAY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hdrQ <= '0;
    else if (st.startHdr) hdrQ <= inWord[HDR_PAY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thruValid <= 1'b0;
      thruWord  <= '0;
      errFlag   <= 1'b0;
      longValid <= 1'b0;
      longData  <= '0;
      longLen   <= '0;
    end else begin
      thruValid <= st.passThru;
      if (st.passThru) thruWord <= inWord;
      errFlag <= st.flagErr;
      if (st.finish) begin
        longValid <= 1'b1;
        longData  <= assembled;
        longLen   <= st.len;
      end else if (longReady) begin
        longValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/long_insn_gather.sv
module long_insn_gather
  import lig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  output logic              thruValid,
  output logic [WORD_W-1:0] thruWord,
  output logic              longValid,
  input  logic              longReady,
  output logic [OUT_W-1:0]  longData,
  output logic [LEN_W-1:0]  longLen,
  output logic              errFlag
);
  ctrlStrobeT st;

  lig_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .longValid(longValid), .longReady(longReady), .inReady(inReady), .st(st)
  );

  lig_datapath uData (
    .clk(clk), .rstN(rstN), .inWord(inWord), .st(st), .longReady(longReady),
    .thruValid(thruValid), .thruWord(thruWord), .longValid(longValid),
    .longData(longData), .longLen(longLen), .errFlag(errFlag)
  );
endmodule

// File: rtl/lig_checker.sv
module lig_checker
  import lig_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [WORD_W-1:0] inWord,
  input logic              inReady,
  input logic              thruValid,
  input logic [WORD_W-1:0] thruWord,
  input logic              longValid,
  input logic              longReady,
  input logic [OUT_W-1:0]  longData,
  input logic [LEN_W-1:0]  longLen,
  input logic              errFlag
);
  logic partWord;
  assign partWord = inWord[31:27] == 5'h1f;

  AST_THRU_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !partWord |=> thruValid && thruWord == $past(inWord)); // R2
  AST_THRU_NEVER_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    !partWord |-> inReady); // R2
  AST_PART_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && partWord |=> !thruValid); // R3
  AST_BAD_LEN_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && partWord && inWord[26:25] == 2'b00 && inWord[24:22] < 3'd2
    |=> errFlag && !longValid); // R6
  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    longValid |-> longLen >= 3'd2); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    longValid && !longReady |=> longValid && $stable(longData) && $stable(longLen)); // R11
  AST_PART_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    longValid && !longReady && partWord |-> !inReady); // R11
  AST_TAKE_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    longValid && longReady |-> inReady); // R12
endmodule

bind long_insn_gather lig_checker chk (.*);

// File: tb/long_insn_gather_test.sv
module long_insn_gather_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [31:0]  inWord = '0;
  logic         inReady;
  logic         thruValid;
  logic [31:0]  thruWord;
  logic         longValid;
  logic         longReady = 1'b1;
  logic [165:0] longData;
  logic [2:0]   longLen;
  logic         errFlag;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  long_insn_gather uut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [165:0] act, input logic [165:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [2:0] len, input logic [21:0] pay);
    return {5'h1f, 2'b00, len, pay};
  endfunction

  function automatic logic [31:0] cont(input logic [2:0] pos, input logic [23:0] pay);
    return {5'h1f, pos, pay};
  endfunction

  function automatic logic [165:0] mkExp(input logic [21:0] hp, input logic [5:0][23:0] parts);
    logic [165:0] e;
    e = {hp, 144'b0};
    for (int i = 0; i < 6; i++) e[143 - 24*i -: 24] = parts[i];
    return e;
  endfunction

  task automatic step(input logic v, input logic [31:0] w);
    @(negedge clk);
    inValid = v;
    inWord = w;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 32'h0);
  endtask

  task automatic expectErr(input string req);
    chk(errFlag == 1'b1, req, errFlag, 1);
    chk(longValid == 1'b0, req, longValid, 0);
  endtask

  task automatic testReset();
    chk(thruValid == 0 && longValid == 0 && errFlag == 0, "R1", {thruValid, longValid, errFlag}, 0);
    chk(inReady == 1, "R1", inReady, 1);
  endtask

  task automatic testPassThru();
    logic [31:0] words [4] = '{32'h1234_5678, 32'hF7FF_FFFF, 32'h0000_0000, 32'hABCD_EF01};
    foreach (words[i]) begin
      step(1'b1, words[i]);
      chk(thruValid && thruWord == words[i], "R2", thruWord, words[i]);
      chk(errFlag == 0 && longValid == 0, "R2", {errFlag, longValid}, 0);
    end
    idle();
    chk(thruValid == 0, "R2", thruValid, 0);
  endtask

  task automatic testInOrder();
    logic [5:0][23:0] p = '0;
    p[0] = 24'hA11111;
    p[1] = 24'hA22222;
    step(1'b1, hdr(3'd3, 22'h2ABCDE));
    chk(!thruValid && !longValid && !errFlag, "R3", {thruValid, longValid, errFlag}, 0);
    step(1'b1, cont(3'd2, p[0]));
    chk(!thruValid && !longValid, "R3", {thruValid, longValid}, 0);
    step(1'b1, cont(3'd3, p[1]));
    chk(longValid == 1, "R4", longValid, 1);
    chk(longLen == 3'd3, "R4", longLen, 3);
    chk(longData == mkExp(22'h2ABCDE, p), "R4", longData, mkExp(22'h2ABCDE, p));
    idle();
    chk(longValid == 0, "R4", longValid, 0);
  endtask

  task automatic testInterleaved();
    logic [5:0][23:0] p;
    logic [2:0] order [6] = '{3'd7, 3'd3, 3'd5, 3'd2, 3'd6, 3'd4};
    for (int i = 0; i < 6; i++) p[i] = 24'hC00000 + 24'(i * 24'h010101);
    step(1'b1, hdr(3'd7, 22'h155555));
    foreach (order[i]) begin
      step(1'b1, 32'h0BAD_0000 + 32'(i));
      chk(thruValid && thruWord == 32'h0BAD_0000 + 32'(i), "R5", thruWord, 32'h0BAD_0000 + 32'(i));
      step(1'b1, cont(order[i], p[order[i] - 3'd2]));
      if (i < 5) chk(!longValid && !errFlag, "R5", {longValid, errFlag}, 0);
    end
    chk(longValid && longLen == 3'd7, "R4", {longValid, longLen}, {1'b1, 3'd7});
    chk(longData == mkExp(22'h155555, p), "R5", longData, mkExp(22'h155555, p));
    idle();
  endtask

  task automatic testBadLen();
    step(1'b1, hdr(3'd0, 22'h1));
    expectErr("R6");
    step(1'b1, hdr(3'd1, 22'h2));
    expectErr("R6");
    step(1'b1, cont(3'd2, 24'h1));
    expectErr("R7");
    idle();
    chk(errFlag == 0, "R7", errFlag, 0);
    step(1'b1, cont(3'd4, 24'h2));
    expectErr("R7");
  endtask

  task automatic testBeyondLen();
    step(1'b1, hdr(3'd3, 22'h3));
    step(1'b1, cont(3'd4, 24'h5));
    expectErr("R8");
    step(1'b1, cont(3'd2, 24'h6));
    expectErr("R8");
    step(1'b1, cont(3'd3, 24'h7));
    expectErr("R8");
  endtask

  task automatic testDuplicate();
    step(1'b1, hdr(3'd3, 22'h4));
    step(1'b1, cont(3'd2, 24'h8));
    chk(errFlag == 0, "R9", errFlag, 0);
    step(1'b1, cont(3'd2, 24'h9));
    expectErr("R9");
    step(1'b1, cont(3'd3, 24'hA));
    expectErr("R9");
  endtask

  task automatic testRestart();
    logic [5:0][23:0] p = '0;
    p[0] = 24'hBEEF01;
    step(1'b1, hdr(3'd4, 22'h0AAAAA));
    step(1'b1, cont(3'd2, 24'h111111));
    step(1'b1, hdr(3'd2, 22'h033333));
    expectErr("R10");
    step(1'b1, cont(3'd2, p[0]));
    chk(longValid && !errFlag && longLen == 3'd2, "R10", {longValid, errFlag, longLen}, {1'b1, 1'b0, 3'd2});
    chk(longData == mkExp(22'h033333, p), "R10", longData, mkExp(22'h033333, p));
    idle();
  endtask

  task automatic testHoldAndTake();
    logic [5:0][23:0] p = '0;
    logic [165:0] held;
    p[0] = 24'h777777;
    longReady = 1'b0;
    step(1'b1, hdr(3'd2, 22'h012345));
    step(1'b1, cont(3'd2, p[0]));
    held = mkExp(22'h012345, p);
    chk(longValid && longData == held, "R11", longData, held);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      inValid = 1'b1;
      inWord = hdr(3'd2, 22'h3FFFFF);
      #1;
      chk(inReady == 0, "R11", inReady, 0);
      @(posedge clk);
      #1;
      chk(longValid && longData == held && longLen == 3'd2, "R11", longData, held);
    end
    step(1'b1, 32'h2222_3333);
    chk(thruValid && thruWord == 32'h2222_3333, "R11", thruWord, 32'h2222_3333);
    chk(longValid && longData == held, "R11", longData, held);
    @(negedge clk);
    longReady = 1'b1;
    inValid = 1'b1;
    inWord = hdr(3'd2, 22'h3FFFFF);
    #1;
    chk(inReady == 1, "R12", inReady, 1);
    @(posedge clk);
    #1;
    chk(longValid == 0 && errFlag == 0, "R12", {longValid, errFlag}, 0);
    p[0] = 24'h999999;
    step(1'b1, cont(3'd2, p[0]));
    chk(longValid && longData == mkExp(22'h3FFFFF, p), "R12", longData, mkExp(22'h3FFFFF, p));
    idle();
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPassThru();
    testInOrder();
    testInterleaved();
    testBadLen();
    testBeyondLen();
    testDuplicate();
    testRestart();
    testHoldAndTake();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule